// File: doc/BRIEF.md
# Bidirectional Parallel Port Handshake Controller

This block runs an 8-bit parallel port that exchanges bytes with a peripheral over a two-wire asynchronous handshake. One active-low strobe output and one active-low acknowledge input are shared between the two transfer directions, and their meaning depends on the direction in use. When sending, the block places a byte on the bus and waits a fixed setup time. It then pulses the strobe low to say the data is ready and waits for the peripheral to pull the acknowledge line low. When receiving, the peripheral pulls the acknowledge line low to say its data is ready. The block captures the bus and answers with a low pulse on the strobe line to say the byte was accepted.

On the host side, outgoing bytes use a valid/ready pair, and each incoming byte appears with a one-cycle valid. A direction request is applied only while no transfer is in progress. Every falling edge of the acknowledge line, whatever the direction, sets a sticky interrupt flag, and an enable input gates that flag onto the interrupt output. Three peripheral status lines (busy, paper-out, select) pass through a synchronizer as plain sampled inputs. The setup time and the pulse width are given in nanoseconds and converted to cycles from a clock-frequency parameter. The defaults (100 MHz, 4800 ns, 1400 ns) give 480 setup cycles and 140 pulse cycles. An optional timeout abandons a send that gets no acknowledge; the default of 20000 ns gives 2000 cycles.

Top module: `par_handshake`

## Requirements
- R1: While reset is high, and after it, strobe_n is 1, the direction is output (mode_act = 0), pd_oe is 1, tx_ready is 1, and rx_valid, tx_err and irq are 0.
- R2: When tx_valid and tx_ready are both high at a clock edge, tx_data appears on pd_out at that edge, and strobe_n falls exactly SETUP_CYC edges later.
- R3: In output mode, strobe_n stays low for exactly PULSE_CYC cycles.
- R4: tx_ready drops when a byte is accepted. If a synchronized falling edge of ack_n arrives while the strobe is low, tx_ready returns in the same cycle that strobe_n rises.
- R5: A falling edge of ack_n before the strobe falls does not complete a send. The send completes only on a later falling edge of ack_n.
- R6: With the timeout enabled, if no acknowledge arrives within TIMEOUT_CYC cycles after the strobe rises, tx_err is high for exactly one cycle, TIMEOUT_CYC edges after the rise, and tx_ready returns in that same cycle.
- R7: pd_oe is 1 exactly when the active direction is output (mode_act = 0) and 0 when it is input (mode_act = 1).
- R8: In input mode, when ack_n falls, pd_in is captured and shown on rx_data with rx_valid high for one cycle, on the third clock edge after the fall. strobe_n goes low in the same cycle and stays low for PULSE_CYC cycles.
- R9: A change on mode_in (0 = output, 1 = input) is applied to mode_act only while no transfer is in progress. A request made during a send takes effect after that send ends.
- R10: Every synchronized falling edge of ack_n sets a sticky flag, which irq_clr clears. irq is high when that flag is set and irq_en is high, and it follows with one register stage.
- R11: stat_q equals stat_in delayed by two clock edges.
- R12: A falling edge of ack_n while the accepted pulse is still low produces no new rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_in | input | 1 | Requested direction: 0 output, 1 input |
| mode_act | output | 1 | Direction currently in force |
| tx_valid | input | 1 | Host has a byte to send |
| tx_data | input | DW | Byte to send |
| tx_ready | output | 1 | Block can accept a byte to send |
| tx_err | output | 1 | One-cycle pulse when a send times out |
| rx_valid | output | 1 | One-cycle pulse when a byte has been received |
| rx_data | output | DW | Received byte |
| pd_in | input | DW | Bus value as read from the pins |
| pd_out | output | DW | Bus value to drive |
| pd_oe | output | 1 | Bus output enable |
| strobe_n | output | 1 | Strobe: data ready when sending, data accepted when receiving (active low) |
| ack_n | input | 1 | Acknowledge: data accepted when sending, data ready when receiving (active low, asynchronous) |
| stat_in | input | SW | Raw peripheral status lines |
| stat_q | output | SW | Synchronized status lines |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the acknowledge-edge flag |
| irq | output | 1 | Interrupt output |

## Verification
The hardest cases to reach are those where the acknowledge arrives at an unusual point in a send. One is an acknowledge that lands inside the strobe pulse. The other is one that comes too early, during the setup window. Both must be placed relative to the strobe edges, so the bench times each send by counting cycles from the strobe's own transitions. It then pulls ack_n low at chosen offsets into the setup window or into the pulse. The same method is used to request a direction change while a send is in progress. In input mode, a second ack_n fall is placed inside the accepted pulse, and the bench checks that no extra byte is delivered.

// File: rtl/par_hs_pkg.sv
package par_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_ACCEPT
  } hs_state_t;

  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } hs_dir_t;

  // Convert a duration in nanoseconds into clock cycles, at least one.
  function automatic int ns_to_cyc(longint hz, longint ns);
    longint c;
    c = (hz / 1000) * ns / 1000000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/par_hs_sync.sv
module par_hs_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/par_hs_irq.sv
module par_hs_irq (
  input  logic clk,
  input  logic rst,
  input  logic ev,
  input  logic clr,
  input  logic en,
  output logic irq_o
);
  logic flag_q;
  logic flag_n;

  always_comb begin
    flag_n = flag_q;
    if (clr) flag_n = 1'b0;
    if (ev)  flag_n = 1'b1;   // a new edge wins over a clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      irq_o  <= flag_n & en;
    end
  end

  // R10: the flag holds until cleared
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/par_hs_ctrl.sv
module par_hs_ctrl
  import par_hs_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 480,
  parameter int PULSE_CYC  = 140,
  parameter bit TIMEOUT_EN = 1'b1,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_req,
  output logic          mode_act,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          tx_err,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic          strobe_n,
  input  logic          ack_s,
  output logic          ack_fall
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > TIMEOUT_CYC) ? SETUP_CYC : TIMEOUT_CYC) :
                        ((PULSE_CYC > TIMEOUT_CYC) ? PULSE_CYC : TIMEOUT_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_M1 = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_M1 = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] TOUT_M1  = CW'(TIMEOUT_CYC - 1);

  hs_state_t     state;
  hs_dir_t       dir_q;
  logic [CW-1:0] cnt;
  logic          ack_d;
  logic          ack_hit;

  assign ack_fall = ack_d & ~ack_s;
  assign mode_act = dir_q;
  assign pd_oe    = (dir_q == DIR_OUT);
  assign tx_ready = (state == ST_IDLE) && (dir_q == DIR_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dir_q    <= DIR_OUT;
      cnt      <= '0;
      strobe_n <= 1'b1;
      pd_out   <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      tx_err   <= 1'b0;
      ack_d    <= 1'b1;
      ack_hit  <= 1'b0;
    end else begin
      ack_d    <= ack_s;
      rx_valid <= 1'b0;
      tx_err   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (dir_q == DIR_OUT && tx_valid) begin
            pd_out  <= tx_data;
            cnt     <= SETUP_M1;
            ack_hit <= 1'b0;
            state   <= ST_SETUP;
          end else if (dir_q == DIR_IN && ack_fall) begin
            rx_data  <= pd_in;
            rx_valid <= 1'b1;
            strobe_n <= 1'b0;
            cnt      <= PULSE_M1;
            state    <= ST_ACCEPT;
          end else begin
            dir_q <= hs_dir_t'(mode_req);
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            strobe_n <= 1'b0;
            cnt      <= PULSE_M1;
            state    <= ST_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (ack_fall) ack_hit <= 1'b1;
          if (cnt == '0) begin
            strobe_n <= 1'b1;
            if (ack_hit || ack_fall) begin
              state <= ST_IDLE;
            end else begin
              cnt   <= TOUT_M1;
              state <= ST_WAIT;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (ack_fall) begin
            state <= ST_IDLE;
          end else if (TIMEOUT_EN && cnt == '0) begin
            tx_err <= 1'b1;
            state  <= ST_IDLE;
          end else if (TIMEOUT_EN) begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACCEPT: begin
          if (cnt == '0) begin
            strobe_n <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: host is never offered a slot while the strobe is low
  assert_ready_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> strobe_n);
  // R9: direction is frozen during a transfer
  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(dir_q));
  // R8: received byte is flagged for a single cycle
  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R8: delivery coincides with the accepted pulse in input direction
  assert_rx_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!strobe_n && dir_q == DIR_IN));
  // R6: timeout error is a single-cycle pulse
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    tx_err |=> !tx_err);
endmodule

// File: rtl/par_handshake.sv
module par_handshake
  import par_hs_pkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter int     DW         = 8,
  parameter int     SW         = 3,
  parameter int     SETUP_NS   = 4800,
  parameter int     PULSE_NS   = 1400,
  parameter bit     TIMEOUT_EN = 1'b1,
  parameter int     TIMEOUT_NS = 20000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_in,
  output logic          mode_act,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          tx_err,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic          strobe_n,
  input  logic          ack_n,
  input  logic [SW-1:0] stat_in,
  output logic [SW-1:0] stat_q,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          irq
);
  localparam int SETUP_CYC   = ns_to_cyc(CLK_HZ, SETUP_NS);
  localparam int PULSE_CYC   = ns_to_cyc(CLK_HZ, PULSE_NS);
  localparam int TIMEOUT_CYC = ns_to_cyc(CLK_HZ, TIMEOUT_NS);

  logic ack_s;
  logic ack_fall;

  par_hs_sync #(.W(1), .STAGES(2), .INIT(1'b1)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_n), .q(ack_s));

  par_hs_sync #(.W(SW), .STAGES(2), .INIT('0)) u_stat_sync (
    .clk(clk), .rst(rst), .d(stat_in), .q(stat_q));

  par_hs_ctrl #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .TIMEOUT_EN(TIMEOUT_EN), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .mode_req(mode_in), .mode_act(mode_act),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_err(tx_err), .rx_valid(rx_valid), .rx_data(rx_data),
    .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .strobe_n(strobe_n),
    .ack_s(ack_s), .ack_fall(ack_fall));

  par_hs_irq u_irq (
    .clk(clk), .rst(rst), .ev(ack_fall), .clr(irq_clr), .en(irq_en),
    .irq_o(irq));
endmodule

// File: tb/test_par_handshake.sv
module test_par_handshake;
  localparam int SETUP = 480;
  localparam int PULSE = 140;
  localparam int TOUT  = 2000;

  logic       clk = 1'b0;
  logic       rst, mode_in, mode_act, tx_valid, tx_ready, tx_err, rx_valid;
  logic [7:0] tx_data, rx_data, pd_in, pd_out;
  logic       pd_oe, strobe_n, ack_n, irq_en, irq_clr, irq;
  logic [2:0] stat_in, stat_q;

  int  checks = 0;
  int  errors = 0;
  int  rx_count = 0;
  bit  done = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  par_handshake i_par_handshake (
    .clk(clk), .rst(rst), .mode_in(mode_in), .mode_act(mode_act),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_err(tx_err), .rx_valid(rx_valid), .rx_data(rx_data),
    .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .strobe_n(strobe_n),
    .ack_n(ack_n), .stat_in(stat_in), .stat_q(stat_q),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor for received bytes
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      rx_count++;
      if (exp_q.size() == 0) check(1'b0, "R12 unexpected rx", rx_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R8 rx_data", rx_data, e);
      end
    end
  end

  task automatic start_send(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send_in(input logic [7:0] b, input bit glitch);
    int n, w;
    pd_in = b; ack_n = 1'b0;
    exp_q.push_back(b);
    n = 0;
    while (!rx_valid && n < 20) begin @(negedge clk); n++; end
    check(n == 3, "R8 rx latency", n, 3);
    check(strobe_n == 1'b0, "R8 strobe with rx", strobe_n, 0);
    w = 0;
    while (!strobe_n && w < PULSE + 20) begin
      w++;
      if (w == 40 && glitch) begin pd_in = 8'hEE; ack_n = 1'b0; end
      if (w == 45 && glitch) ack_n = 1'b1;
      @(negedge clk);
      if (w == 1) begin
        check(rx_valid == 1'b0, "R8 rx one cycle", rx_valid, 0);
        ack_n = 1'b1;
      end
    end
    check(w == PULSE, "R8 accepted pulse width", w, PULSE);
    tick(10);
  endtask

  initial begin
    int n, w;
    rst = 1'b1; mode_in = 1'b0; tx_valid = 1'b0; tx_data = '0; pd_in = '0;
    ack_n = 1'b1; stat_in = '0; irq_en = 1'b0; irq_clr = 1'b0;
    tick(3);
    check(strobe_n && tx_ready && !mode_act && pd_oe && !rx_valid && !tx_err && !irq,
          "R1 reset state", {strobe_n, tx_ready, mode_act, pd_oe}, 4'b1101);
    rst = 1'b0;
    tick(2);
    check(strobe_n && tx_ready && !irq, "R1 after reset", {strobe_n, tx_ready}, 2'b11);

    // Send with acknowledge inside the strobe pulse
    start_send(8'hA5);
    check(tx_ready == 1'b0, "R4 ready drops", tx_ready, 0);
    n = 0;
    while (strobe_n && n < SETUP + 50) begin @(negedge clk); n++; end
    check(n == SETUP, "R2 setup cycles", n, SETUP);
    check(pd_out == 8'hA5 && pd_oe, "R2 bus data", pd_out, 8'hA5);
    w = 0;
    while (!strobe_n && w < PULSE + 50) begin
      w++;
      if (w == 10) ack_n = 1'b0;
      if (w == 15) ack_n = 1'b1;
      @(negedge clk);
    end
    check(w == PULSE, "R3 strobe width", w, PULSE);
    check(tx_ready == 1'b1, "R4 ready on strobe rise", tx_ready, 1);
    tick(5);

    // Early acknowledge plus deferred direction change
    start_send(8'h3C);
    tick(100);
    ack_n = 1'b0; tick(5); ack_n = 1'b1;
    mode_in = 1'b1;
    tick(3);
    check(mode_act == 1'b0 && pd_oe == 1'b1, "R9 mode held in send", mode_act, 0);
    while (strobe_n) @(negedge clk);
    while (!strobe_n) @(negedge clk);
    tick(5);
    check(mode_act == 1'b0, "R5 early ack ignored", mode_act, 0);
    ack_n = 1'b0; tick(5); ack_n = 1'b1;
    tick(2);
    check(mode_act == 1'b1, "R9 mode applied after send", mode_act, 1);
    check(pd_oe == 1'b0, "R7 bus released in input", pd_oe, 0);
    check(tx_err == 1'b0, "R5 no error", tx_err, 0);

    // Input direction
    send_in(8'h5A, 1'b0);
    send_in(8'hC3, 1'b0);
    send_in(8'h11, 1'b1);
    check(rx_count == 3 && exp_q.size() == 0, "R12 byte count", rx_count, 3);

    // Timeout
    mode_in = 1'b0;
    tick(3);
    check(mode_act == 1'b0 && pd_oe == 1'b1, "R7 bus driven in output", pd_oe, 1);
    start_send(8'h77);
    while (strobe_n) @(negedge clk);
    while (!strobe_n) @(negedge clk);
    n = 0;
    while (!tx_err && n < TOUT + 50) begin @(negedge clk); n++; end
    check(n == TOUT, "R6 timeout cycles", n, TOUT);
    check(tx_ready == 1'b1, "R6 ready after timeout", tx_ready, 1);
    tick(1);
    check(tx_err == 1'b0, "R6 error one cycle", tx_err, 0);

    // Interrupt flag
    check(irq == 1'b0, "R10 masked", irq, 0);
    irq_en = 1'b1; tick(1);
    check(irq == 1'b1, "R10 sticky flag unmasked", irq, 1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    check(irq == 1'b0, "R10 cleared", irq, 0);
    ack_n = 1'b0; tick(4); ack_n = 1'b1;
    check(irq == 1'b1, "R10 set by edge", irq, 1);
    tick(5);
    check(irq == 1'b1, "R10 stays set", irq, 1);

    // Status synchronizer
    stat_in = 3'b101; tick(1);
    check(stat_q == 3'b000, "R11 one edge", stat_q, 0);
    tick(1);
    check(stat_q == 3'b101, "R11 two edges", stat_q, 5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule